// File: doc/BRIEF.md
# Piecewise-Linear Gamma Curve Engine

This block applies a single shared gamma curve to a stream of 12-bit pixel components. The curve is given by software as a full table of 4096 sample points, one per input code. A builder condenses that table into 64 linear segments, each stored as one packed word that holds a slope and a start value. An evaluator then maps each incoming code to its segment and interpolates along that segment's line.

Segments are narrow near black and wider toward white. The first sixteen segments are one code wide. Five groups of four segments follow, with widths of 4, 8, 16, 32 and 64 codes. Twenty-eight segments of 128 codes each cover 512 up to 4095. Each curve sample carries red, green and blue values, and one curve is shared by all three channels. If any sample written since the previous build has channels that disagree, the build is refused and the current table is kept.

To use the block, write the samples through the curve port, pulse the build start and wait for the done pulse. After that, stream pixels through the valid/ready path.

Top module: `gamma_pwl_engine`

## Requirements
- R1: An input code x below 16 belongs to segment x. For 16 ≤ x ≤ 511, let m be the position of x's highest set bit (4..8). The segment is 16 + 4·(m−4) + ((x >> (m−2)) & 3), and its width is 2^(m−2). For x ≥ 512 the segment is 32 + (x >> 7), and its width is 128.
- R2: A write on the curve port sets the curve sample at the given 12-bit address to the green value. The curve value of a segment's first and last code is taken from the most recent write to that address before the build.
- R3: For a segment with first code s, last code e and span e−s, the builder computes the slope as floor((C(e)−C(s))·256 / (e−s)), keeping the low 12 bits. The slope is 0 when the span is 0 or when C(e) ≤ C(s). The stored packed word holds the slope in bits 27:16 and C(s) in bits 11:0.
- R4: Every segment below code 16 gets slope 0, so each code 0..15 outputs exactly its own curve value.
- R5: The output for input x is min(4095, C(s) + (((x−s)·slope) >> 8)), where s is the first code of x's segment.
- R6: A build start while idle, with all samples written since the last build having equal red, green and blue, raises busy on the next cycle. Busy stays high for 64 cycles. It then falls together with a one-cycle done pulse, with ok high, and the new table is in force.
- R7: If any write since the last build had unequal channels, a build start gives a done pulse with ok low on the next cycle. Busy never rises, and the previous table keeps producing the same outputs.
- R8: A pixel accepted at a clock edge appears on the output, valid, after the second following edge when out_ready is held high.
- R9: While out_valid is high and out_ready is low, out_data and out_valid hold and in_ready is low.
- R10: While busy, curve writes and build starts are ignored. They change neither the table being built nor the accept/reject decision of the next build.
- R11: After reset, out_valid, busy and done are low, in_ready is high, and the table is all zero, so every input outputs 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cw_en | input | 1 | Curve sample write strobe |
| cw_addr | input | 12 | Curve sample address (input code) |
| cw_red | input | 12 | Red channel of the sample |
| cw_green | input | 12 | Green channel of the sample (stored) |
| cw_blue | input | 12 | Blue channel of the sample |
| build_start | input | 1 | Request to build the segment table |
| build_busy | output | 1 | Segment table build in progress |
| build_done | output | 1 | One-cycle pulse when a build ends or is refused |
| build_ok | output | 1 | Build outcome, valid with build_done |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high with in_valid |
| in_data | input | 12 | Input pixel code |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream ready |
| out_data | output | 12 | Gamma-corrected pixel code |

## Verification
The bench aims at the segment edges: codes 15/16, 511/512, 4095 and the first and last code of each sector. An off-by-one in the leading-one decode would interpolate from the wrong start point, and the error is largest at those edges. A falling, hash-like curve checks the slope clamp and the 12-bit wrap of large slopes; a slope taken as signed, or left unmasked, gives wildly wrong outputs. The bench corrupts one sample's blue channel to trigger a refused build, then probes the old table. It also hammers the port with writes and extra start pulses during a build. A design that honours those would show a second done pulse, a refused next build, or a drifted curve. Random backpressure catches any output that moves while stalled.

// File: rtl/gamma_pwl_engine.sv
`timescale 1ns/1ps
module gamma_pwl_engine #(
  parameter int DW   = 12,
  parameter int FRAC = 8,
  parameter int FINE = 16,
  parameter int GRP  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cw_en,
  input  logic [DW-1:0] cw_addr,
  input  logic [DW-1:0] cw_red,
  input  logic [DW-1:0] cw_green,
  input  logic [DW-1:0] cw_blue,
  input  logic          build_start,
  output logic          build_busy,
  output logic          build_done,
  output logic          build_ok,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  localparam int FL    = $clog2(FINE);
  localparam int GL    = $clog2(GRP);
  localparam int CSH   = DW - 5;
  localparam int NMID  = (CSH + 2 - FL) * GRP;
  localparam int CBASE = FINE + NMID;
  localparam int NSEG  = CBASE + (1 << (DW - CSH)) - (1 << GL);
  localparam int SGW   = $clog2(NSEG);
  localparam int PW    = 16 + DW;
  localparam int NW    = DW + FRAC;

  typedef struct packed {
    logic [SGW-1:0] seg;
    logic [CSH-1:0] pos;
    logic [CSH-1:0] span;
  } loc_t;

  function automatic loc_t locate(input logic [DW-1:0] x);
    loc_t r;
    int   msb;
    int   sh;
    int   xi;
    xi  = int'(x);
    msb = 0;
    for (int b = 0; b < DW; b++)
      if (x[b]) msb = b;
    r = '0;
    if (xi < FINE) begin
      r.seg = SGW'(xi);
    end else if (msb < CSH + GL) begin
      sh     = msb - GL;
      r.seg  = SGW'(FINE + (msb - FL) * GRP + ((xi >> sh) & (GRP - 1)));
      r.pos  = CSH'(xi & ((1 << sh) - 1));
      r.span = CSH'((1 << sh) - 1);
    end else begin
      r.seg  = SGW'(CBASE - (1 << GL) + (xi >> CSH));
      r.pos  = x[CSH-1:0];
      r.span = {CSH{1'b1}};
    end
    return r;
  endfunction

  function automatic logic [CSH-1:0] span_of(input logic [SGW-1:0] i);
    int ii;
    ii = int'(i);
    if (ii < FINE)       return '0;
    else if (ii < CBASE) return CSH'((1 << ((ii - FINE) / GRP + FL - GL)) - 1);
    else                 return {CSH{1'b1}};
  endfunction

  // curve sample capture: only segment first/last codes are kept
  logic [DW-1:0] s_val [NSEG];
  logic [DW-1:0] e_val [NSEG];
  loc_t          loc_w;
  logic          wr_ok, wr_bad;

  assign loc_w  = locate(cw_addr);
  assign wr_ok  = cw_en && !build_busy;
  assign wr_bad = wr_ok && ((cw_red != cw_green) || (cw_blue != cw_green));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSEG; i++) begin
        s_val[i] <= '0;
        e_val[i] <= '0;
      end
    end else if (wr_ok) begin
      if (loc_w.pos == '0)         s_val[loc_w.seg] <= cw_green;
      if (loc_w.pos == loc_w.span) e_val[loc_w.seg] <= cw_green;
    end
  end

  // table builder: one segment per cycle
  logic [PW-1:0]  coef [NSEG];
  logic [SGW-1:0] bidx;
  logic           bad;
  logic [DW-1:0]  b_sv, b_ev;
  logic [CSH-1:0] b_span;
  logic [NW-1:0]  b_num, b_quo;
  logic [PW-1:0]  bword;

  assign b_sv   = s_val[bidx];
  assign b_ev   = e_val[bidx];
  assign b_span = span_of(bidx);
  assign b_num  = (b_ev > b_sv) ? (NW'(b_ev - b_sv) << FRAC) : '0;
  assign b_quo  = (b_span == '0) ? '0 : b_num / NW'(b_span);
  assign bword  = {b_quo[DW-1:0], {(16-DW){1'b0}}, b_sv};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      build_busy <= 1'b0;
      build_done <= 1'b0;
      build_ok   <= 1'b0;
      bad        <= 1'b0;
      bidx       <= '0;
      for (int i = 0; i < NSEG; i++) coef[i] <= '0;
    end else begin
      build_done <= 1'b0;
      if (build_busy) begin
        coef[bidx] <= bword;
        bidx       <= bidx + 1'b1;
        if (bidx == SGW'(NSEG - 1)) begin
          build_busy <= 1'b0;
          build_done <= 1'b1;
          build_ok   <= 1'b1;
        end
      end else if (build_start) begin
        bad  <= 1'b0;
        bidx <= '0;
        if (bad || wr_bad) begin
          build_done <= 1'b1;
          build_ok   <= 1'b0;
        end else begin
          build_busy <= 1'b1;
        end
      end else if (wr_bad) begin
        bad <= 1'b1;
      end
    end
  end

  p_fine_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (build_busy && (int'(bidx) < FINE)) |-> (bword[PW-1:16] == '0));
  p_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (build_start && !build_busy && !bad && !wr_bad) |=> build_busy);
  p_finish_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(build_busy) |-> (build_done && build_ok));
  p_refuse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (build_start && !build_busy && (bad || wr_bad)) |=> (build_done && !build_ok && !build_busy));
  p_busy_deaf_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (build_busy && cw_en) |=> ($stable(s_val[0]) && $stable(e_val[NSEG-1])));

  // evaluator: stage 1 locates, stage 2 interpolates
  logic           adv, s1_v;
  logic [SGW-1:0] s1_seg;
  logic [CSH-1:0] s1_pos;
  loc_t           loc_i;
  logic [DW-1:0]  e_slope, e_start;
  logic [16-DW-1:0] pad_unused;
  logic [CSH+DW-1:0] prod;
  logic [DW:0]    sum;
  logic [DW-1:0]  res;

  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;
  assign loc_i    = locate(in_data);
  assign {e_slope, pad_unused, e_start} = coef[s1_seg];
  assign prod     = (CSH+DW)'(s1_pos) * (CSH+DW)'(e_slope);
  assign sum      = {1'b0, e_start} + (DW+1)'(prod >> FRAC);
  assign res      = sum[DW] ? {DW{1'b1}} : sum[DW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v      <= 1'b0;
      s1_seg    <= '0;
      s1_pos    <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (adv) begin
      s1_v      <= in_valid;
      s1_seg    <= loc_i.seg;
      s1_pos    <= loc_i.pos;
      out_valid <= s1_v;
      if (s1_v) out_data <= res;
    end
  end

  p_take_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> s1_v);
  p_emit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_v && in_ready) |=> out_valid);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

// File: tb/test_gamma_pwl_engine.sv
`timescale 1ns/1ps
module test_gamma_pwl_engine;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cw_en;
  logic [11:0] cw_addr, cw_red, cw_green, cw_blue;
  logic        build_start;
  logic        build_busy, build_done, build_ok;
  logic        in_valid, in_ready;
  logic [11:0] in_data;
  logic        out_valid, out_ready;
  logic [11:0] out_data;

  int n_chk = 0;
  int n_err = 0;
  int corners[21] = '{0, 15, 16, 19, 20, 23, 24, 31, 32, 63, 64, 255, 256,
                      511, 512, 639, 640, 2047, 2048, 4094, 4095};

  always #10 clk = ~clk;

  gamma_pwl_engine i_gamma_pwl_engine (
    .clk(clk), .rst_n(rst_n),
    .cw_en(cw_en), .cw_addr(cw_addr), .cw_red(cw_red), .cw_green(cw_green), .cw_blue(cw_blue),
    .build_start(build_start), .build_busy(build_busy), .build_done(build_done), .build_ok(build_ok),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  task automatic chk(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  function automatic int curve(int mode, int k);
    int unsigned h;
    case (mode)
      0: return k;
      1: return (k * k) >> 12;
      2: begin h = 32'(k) * 32'd2654435761; return int'((h >> 13) & 32'hFFF); end
      3: return 4095 - k;
      default: return 0;
    endcase
  endfunction

  function automatic int seg_start(int i);
    int j;
    if (i < 16) return i;
    if (i < 36) begin j = i - 16; return (16 << (j / 4)) + (j % 4) * (4 << (j / 4)); end
    return 512 + (i - 36) * 128;
  endfunction

  function automatic int seg_width(int i);
    if (i < 16) return 1;
    if (i < 36) return 4 << ((i - 16) / 4);
    return 128;
  endfunction

  function automatic int expect_out(int mode, int x);
    int st, w, s, e, sl, r;
    if (mode < 0) return 0;
    for (int i = 0; i < 64; i++) begin
      st = seg_start(i);
      w  = seg_width(i);
      if (x >= st && x < st + w) begin
        s  = curve(mode, st);
        e  = curve(mode, st + w - 1);
        sl = (w == 1 || e <= s) ? 0 : (((e - s) * 256) / (w - 1)) & 4095;
        r  = s + (((x - st) * sl) >> 8);
        return (r > 4095) ? 4095 : r;
      end
    end
    return -1;
  endfunction

  task automatic load_curve(int mode, int bad_at);
    for (int k = 0; k < 4096; k++) begin
      @(negedge clk);
      cw_en    = 1'b1;
      cw_addr  = 12'(k);
      cw_green = 12'(curve(mode, k));
      cw_red   = cw_green;
      cw_blue  = (k == bad_at) ? (cw_green ^ 12'd1) : cw_green;
    end
    @(negedge clk);
    cw_en = 1'b0;
  endtask

  task automatic run_build(bit exp_ok);
    int cyc = 0;
    @(negedge clk);
    build_start = 1'b1;
    @(negedge clk);
    build_start = 1'b0;
    if (exp_ok) begin
      chk("R6 busy after start", int'(build_busy), 1);
      chk("R6 no early done", int'(build_done), 0);
      while (!build_done && cyc < 500) begin
        @(negedge clk);
        cyc++;
      end
      chk("R6 build length", cyc, 64);
      chk("R6 accepted", int'(build_ok), 1);
      chk("R6 busy cleared", int'(build_busy), 0);
    end else begin
      chk("R7 refusal done", int'(build_done), 1);
      chk("R7 refusal ok low", int'(build_ok), 0);
      chk("R7 never busy", int'(build_busy), 0);
    end
  endtask

  task automatic stream(int mode, int n, bit bp, string tag);
    int q[$];
    int sent = 0;
    int guard = 0;
    bit held = 1'b0;
    int hd = 0;
    while ((sent < n || q.size() > 0) && guard < 40 * n + 100) begin
      @(negedge clk);
      guard++;
      if (held) begin
        chk("R9 held valid", int'(out_valid), 1);
        chk("R9 held data", int'(out_data), hd);
      end
      out_ready = bp ? ($urandom % 3 != 0) : 1'b1;
      if (sent < n && ($urandom % 4 != 0)) begin
        in_valid = 1'b1;
        in_data  = (sent < 21) ? 12'(corners[sent]) : 12'($urandom % 4096);
      end else begin
        in_valid = 1'b0;
      end
      #1;
      if (out_valid && !out_ready) chk("R9 in_ready low while stalled", int'(in_ready), 0);
      if (in_valid && in_ready) begin
        q.push_back(expect_out(mode, int'(in_data)));
        sent++;
      end
      if (out_valid && out_ready) begin
        if (q.size() == 0) chk({tag, " unexpected output"}, 1, 0);
        else chk(tag, int'(out_data), q.pop_front());
      end
      held = out_valid && !out_ready;
      hd   = int'(out_data);
    end
    in_valid  = 1'b0;
    out_ready = 1'b1;
    chk({tag, " stream drained"}, q.size() + ((sent < n) ? 1 : 0), 0);
  endtask

  initial begin
    #4_000_000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int dones;
    void'($urandom(32'd4711));
    rst_n = 1'b0; cw_en = 1'b0; cw_addr = '0; cw_red = '0; cw_green = '0; cw_blue = '0;
    build_start = 1'b0; in_valid = 1'b0; in_data = '0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 out_valid after reset", int'(out_valid), 0);
    chk("R11 busy after reset", int'(build_busy), 0);
    chk("R11 done after reset", int'(build_done), 0);
    chk("R11 in_ready after reset", int'(in_ready), 1);
    stream(-1, 30, 1'b0, "R11 zero table");

    load_curve(0, -1);
    run_build(1'b1);
    stream(0, 60, 1'b1, "R5 identity curve (R1 R2 R3)");

    // R8: latency of two edges
    repeat (3) @(negedge clk);
    in_valid = 1'b1; in_data = 12'd1000;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 not valid after one edge", int'(out_valid), 0);
    @(negedge clk);
    chk("R8 valid after two edges", int'(out_valid), 1);
    chk("R8 data after two edges", int'(out_data), expect_out(0, 1000));
    @(negedge clk);

    load_curve(1, -1);
    run_build(1'b1);
    stream(1, 200, 1'b1, "R5 square curve (R1 R3)");

    // R7: one bad sample refuses the build, old table stays
    load_curve(2, 777);
    run_build(1'b0);
    stream(1, 40, 1'b0, "R7 old table kept");

    load_curve(2, -1);
    run_build(1'b1);
    stream(2, 200, 1'b1, "R3 R4 hash curve with clamp");

    // R10: traffic while busy is ignored
    @(negedge clk);
    build_start = 1'b1;
    @(negedge clk);
    build_start = 1'b0;
    chk("R10 busy", int'(build_busy), 1);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      cw_en = 1'b1; cw_addr = 12'(i * 37); cw_red = 12'd1; cw_green = 12'd2; cw_blue = 12'd3;
      build_start = (i == 5);
    end
    @(negedge clk);
    cw_en = 1'b0; build_start = 1'b0;
    dones = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (build_done) begin
        dones++;
        chk("R10 build still accepted", int'(build_ok), 1);
      end
    end
    chk("R10 single done pulse", dones, 1);
    stream(2, 80, 1'b1, "R10 curve unchanged by busy writes");
    run_build(1'b1);
    stream(2, 40, 1'b0, "R10 rebuild after ignored writes");

    load_curve(3, -1);
    run_build(1'b1);
    stream(3, 60, 1'b1, "R3 falling curve");

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule